// File: doc/BRIEF.md
# Dual-Width Banked Scratch-Pad Buffer

This block is a 1 kB scratch-pad store with two ways in. Load and store sequencers use the wide port. Each wide access moves one whole 256-bit row. A wide write can update any subset of the row's eight 32-bit lanes, and a wide read returns the full row one clock after the request.

A host processor uses an APB slave port to read and write single 32-bit words through its memory map. The buffer sits at byte address 0x0000_C000 inside the peripheral region. The port answers with an error for any address outside its 1 kB window.

The storage is split into eight lane-wide banks. A wide access touches every bank of one row, and a narrow access touches one bank. Both ports can be served in the same clock. The only exception is when both ports address the same row. In that case the wide port goes first, and the APB transfer takes one extra cycle.

Top module: `scratchBuf`

## Requirements
- R1: After reset, wideRvalid is 0, wideRdata is all zeros, and pready and pslverr are 0.
- R2: A wide write updates only the lanes whose wideLaneEn bit is set. Lane i is bits [32i+31:32i] of wideWdata, and every other lane of the row keeps its value.
- R3: A wide read with wideEn=1 and wideWe=0 makes wideRvalid high for the next cycle, with the row registered on wideRdata. Bank 0 is in bits [31:0] and bank 7 is in bits [255:224].
- R4: On the APB port, byte address 0x0000_C000 + 32*row + 4*bank reaches word `bank` (0..7) of row `row` (0..31). A read or write completes in its first access cycle with pready=1 and pslverr=0 when the wide port is not using that row.
- R5: An APB write changes only the bytes whose pstrb bit is set. pstrb[k] covers pwdata bits [8k+7:8k].
- R6: An access outside 0x0000_C000..0x0000_C3FF completes at once with pready=1 and pslverr=1. It returns prdata=0 and changes no stored word.
- R7: If the wide port is active on the same row during an APB access cycle, the wide port is served first. pready stays low for exactly one cycle, and the transfer then completes; a read then sees the wide port's new data.
- R8: A wide access to a different row in the same cycle adds no wait state to the APB transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wideEn | input | 1 | Wide port request |
| wideWe | input | 1 | Wide port direction, 1 = write |
| wideRow | input | 5 | Row addressed by the wide port |
| wideLaneEn | input | 8 | Per-lane write enable for a wide write |
| wideWdata | input | 256 | Wide write data |
| wideRdata | output | 256 | Registered wide read data |
| wideRvalid | output | 1 | wideRdata holds the row read in the previous cycle |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | 32 | APB byte address |
| pwdata | input | 32 | APB write data |
| pstrb | input | 4 | APB byte strobes |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB transfer complete |
| pslverr | output | 1 | APB error response |

## Verification
The bench checks the same-row clash. A design that ignores the clash would either return the stale word or never release pready. It also checks that a wide read on another row adds no wait state. Writes outside the window are followed by a read of the word they would alias to, so a decoder that drops the upper address bits shows up as a corrupted word. Partial byte strobes and partial lane enables are each read back through the other port, which exposes a bank or byte slice that is swapped or written whole.

// File: rtl/scratch_pkg.sv
package scratch_pkg;

  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic laneRd;   // narrow read of one bank word
    logic laneWr;   // narrow write of one bank word
    logic wideRd;   // full-row read
    logic wideWr;   // full-row write under lane enables
  } bufStrobe_t;

endpackage

// File: rtl/scratchCtrl.sv
module scratchCtrl
  import scratch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROWS   = 32,
  parameter int BANKS  = 8,
  parameter int LANE_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_C000,
  localparam int BYTE_AW = $clog2(LANE_W / 8),
  localparam int BANK_AW = $clog2(BANKS),
  localparam int ROW_AW  = $clog2(ROWS),
  localparam int WIN_AW  = BYTE_AW + BANK_AW + ROW_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              wideEn,
  input  logic              wideWe,
  input  logic [ROW_AW-1:0] wideRow,
  output bufStrobe_t        strobe,
  output logic [ROW_AW-1:0] narrowRow,
  output logic [BANK_AW-1:0] narrowBank,
  output logic              pready,
  output logic              pslverr
);

  logic accessPhase;
  logic inWindow;
  logic rowClash;
  logic holdOff;
  logic waited;
  logic unusedByteBits;

  assign accessPhase    = psel && penable;
  assign inWindow       = (paddr[ADDR_W-1:WIN_AW] == BASE_ADDR[ADDR_W-1:WIN_AW]);
  assign narrowBank     = paddr[BYTE_AW +: BANK_AW];
  assign narrowRow      = paddr[BYTE_AW + BANK_AW +: ROW_AW];
  assign unusedByteBits = ^paddr[BYTE_AW-1:0];

  // The wide port owns a row it touches; the narrow port yields once.
  assign rowClash = wideEn && (wideRow == narrowRow);
  assign holdOff  = accessPhase && inWindow && rowClash && !waited;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waited <= 1'b0;
    end else begin
      waited <= holdOff;
    end
  end

  assign pready  = accessPhase && !holdOff;
  assign pslverr = accessPhase && !inWindow;

  always_comb begin
    strobe        = '0;
    strobe.laneRd = accessPhase && inWindow && !holdOff && !pwrite;
    strobe.laneWr = accessPhase && inWindow && !holdOff && pwrite;
    strobe.wideRd = wideEn && !wideWe;
    strobe.wideWr = wideEn && wideWe;
  end

endmodule

// File: rtl/scratchDatapath.sv
module scratchDatapath
  import scratch_pkg::*;
#(
  parameter int ROWS   = 32,
  parameter int BANKS  = 8,
  parameter int LANE_W = 32,
  localparam int BYTES   = LANE_W / 8,
  localparam int ROW_W   = LANE_W * BANKS,
  localparam int BANK_AW = $clog2(BANKS),
  localparam int ROW_AW  = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  bufStrobe_t         strobe,
  input  logic [ROW_AW-1:0]  narrowRow,
  input  logic [BANK_AW-1:0] narrowBank,
  input  logic [LANE_W-1:0]  pwdata,
  input  logic [BYTES-1:0]   pstrb,
  input  logic [ROW_AW-1:0]  wideRow,
  input  logic [BANKS-1:0]   wideLaneEn,
  input  logic [ROW_W-1:0]   wideWdata,
  output logic [LANE_W-1:0]  prdata,
  output logic [ROW_W-1:0]   wideRdata,
  output logic               wideRvalid
);

  logic [LANE_W-1:0] laneWord [BANKS];
  logic [ROW_W-1:0]  rowWord;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [LANE_W-1:0] cells [ROWS];
    logic narrowHit;

    assign narrowHit = strobe.laneWr && (narrowBank == BANK_AW'(b));

    // The wide write comes last, so it wins a lane that both ports write.
    always_ff @(posedge clk) begin
      if (narrowHit) begin
        for (int k = 0; k < BYTES; k++) begin
          if (pstrb[k]) cells[narrowRow][k*8 +: 8] <= pwdata[k*8 +: 8];
        end
      end
      if (strobe.wideWr && wideLaneEn[b]) begin
        cells[wideRow] <= wideWdata[b*LANE_W +: LANE_W];
      end
    end

    assign laneWord[b]                  = cells[narrowRow];
    assign rowWord[b*LANE_W +: LANE_W]  = cells[wideRow];
  end

  assign prdata = strobe.laneRd ? laneWord[narrowBank] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wideRvalid <= 1'b0;
      wideRdata  <= '0;
    end else begin
      wideRvalid <= strobe.wideRd;
      if (strobe.wideRd) wideRdata <= rowWord;
    end
  end

endmodule

// File: rtl/scratchBuf.sv
module scratchBuf
  import scratch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROWS   = 32,
  parameter int BANKS  = 8,
  parameter int LANE_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_C000,
  localparam int BYTES   = LANE_W / 8,
  localparam int ROW_W   = LANE_W * BANKS,
  localparam int BANK_AW = $clog2(BANKS),
  localparam int ROW_AW  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wideEn,
  input  logic              wideWe,
  input  logic [ROW_AW-1:0] wideRow,
  input  logic [BANKS-1:0]  wideLaneEn,
  input  logic [ROW_W-1:0]  wideWdata,
  output logic [ROW_W-1:0]  wideRdata,
  output logic              wideRvalid,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [LANE_W-1:0] pwdata,
  input  logic [BYTES-1:0]  pstrb,
  output logic [LANE_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr
);

  bufStrobe_t         strobe;
  logic [ROW_AW-1:0]  narrowRow;
  logic [BANK_AW-1:0] narrowBank;

  scratchCtrl #(
    .ADDR_W(ADDR_W), .ROWS(ROWS), .BANKS(BANKS), .LANE_W(LANE_W), .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .wideEn(wideEn), .wideWe(wideWe), .wideRow(wideRow),
    .strobe(strobe), .narrowRow(narrowRow), .narrowBank(narrowBank),
    .pready(pready), .pslverr(pslverr)
  );

  scratchDatapath #(
    .ROWS(ROWS), .BANKS(BANKS), .LANE_W(LANE_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .narrowRow(narrowRow), .narrowBank(narrowBank),
    .pwdata(pwdata), .pstrb(pstrb),
    .wideRow(wideRow), .wideLaneEn(wideLaneEn), .wideWdata(wideWdata),
    .prdata(prdata), .wideRdata(wideRdata), .wideRvalid(wideRvalid)
  );

endmodule

// File: rtl/scratchBufChecker.sv
module scratchBufChecker #(
  parameter int LANE_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              psel,
  input logic              penable,
  input logic              pready,
  input logic              pslverr,
  input logic [LANE_W-1:0] prdata,
  input logic              wideEn,
  input logic              wideWe,
  input logic              wideRvalid
);

  // R6: an error is only ever a completed access-phase response
  a_r6_err_in_access: assert property (@(posedge clk) disable iff (!rstN)
    pslverr |-> (psel && penable && pready));

  // R6: an error response carries no data
  a_r6_err_zero_data: assert property (@(posedge clk) disable iff (!rstN)
    (pready && pslverr) |-> (prdata == '0));

  // R7: at most one wait state while the master holds the transfer
  a_r7_single_wait: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && !pready) |=> (!(psel && penable) || pready));

  // R7: a wait state needs the wide port to be busy
  a_r7_wait_needs_wide: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && !pready) |-> wideEn);

  // R8: with the wide port idle the transfer never waits
  a_r8_idle_no_wait: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && !wideEn) |-> pready);

  // R3: a wide read yields valid data on the next cycle
  a_r3_valid_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    (wideEn && !wideWe) |=> wideRvalid);

  // R3: valid only after a wide read
  a_r3_valid_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    wideRvalid |-> $past(wideEn && !wideWe));

endmodule

bind scratchBuf scratchBufChecker #(.LANE_W(LANE_W)) u_chk (.*);

// File: tb/test_scratchBuf.sv
module test_scratchBuf;

  logic         clk = 1'b0;
  logic         rstN;
  logic         wideEn, wideWe;
  logic [4:0]   wideRow;
  logic [7:0]   wideLaneEn;
  logic [255:0] wideWdata, wideRdata;
  logic         wideRvalid;
  logic         psel, penable, pwrite;
  logic [31:0]  paddr, pwdata, prdata;
  logic [3:0]   pstrb;
  logic         pready, pslverr;

  always #2 clk = ~clk;

  scratchBuf i_scratchBuf (
    .clk(clk), .rstN(rstN),
    .wideEn(wideEn), .wideWe(wideWe), .wideRow(wideRow), .wideLaneEn(wideLaneEn),
    .wideWdata(wideWdata), .wideRdata(wideRdata), .wideRvalid(wideRvalid),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [31:0] exp;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_C000, 32'h1122_3344, 4'hF, 32'h0,         1'b0, 4'd4}, // R4 row0 bank0
    '{1'b0, 32'h0000_C000, 32'h0,         4'h0, 32'h1122_3344, 1'b0, 4'd4}, // R4
    '{1'b1, 32'h0000_C3FC, 32'hAABB_CCDD, 4'hF, 32'h0,         1'b0, 4'd4}, // R4 row31 bank7
    '{1'b0, 32'h0000_C3FC, 32'h0,         4'h0, 32'hAABB_CCDD, 1'b0, 4'd4}, // R4
    '{1'b1, 32'h0000_C000, 32'hFFFF_FFFF, 4'h5, 32'h0,         1'b0, 4'd5}, // R5 bytes 0,2
    '{1'b0, 32'h0000_C000, 32'h0,         4'h0, 32'h11FF_33FF, 1'b0, 4'd5}, // R5
    '{1'b1, 32'h0000_C024, 32'hCAFE_F00D, 4'hF, 32'h0,         1'b0, 4'd4}, // R4 row1 bank1
    '{1'b0, 32'h0000_C024, 32'h0,         4'h0, 32'hCAFE_F00D, 1'b0, 4'd4}, // R4
    '{1'b1, 32'h0000_C400, 32'hDEAD_BEEF, 4'hF, 32'h0,         1'b1, 4'd6}, // R6 past window
    '{1'b1, 32'h0001_C000, 32'hDEAD_BEEF, 4'hF, 32'h0,         1'b1, 4'd6}, // R6 alias of base
    '{1'b0, 32'h0000_C000, 32'h0,         4'h0, 32'h11FF_33FF, 1'b0, 4'd6}, // R6 untouched
    '{1'b0, 32'h0000_C400, 32'h0,         4'h0, 32'h0,         1'b1, 4'd6}, // R6
    '{1'b0, 32'h0000_B000, 32'h0,         4'h0, 32'h0,         1'b1, 4'd6}  // R6 below base
  };

  int  vecs = 0;
  int  miss = 0;
  bit  done = 1'b0;

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apbXfer(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                         input logic [3:0] st, output logic [31:0] rd, output logic err,
                         output int waits);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = wd; pstrb = st;
    @(negedge clk);
    penable = 1'b1; waits = 0;
    #1;
    while (!pready && waits < 8) begin
      waits++;
      @(negedge clk);
      #1;
    end
    rd = prdata; err = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wideWrite(input logic [4:0] row, input logic [7:0] en, input logic [255:0] d);
    @(negedge clk);
    wideEn = 1'b1; wideWe = 1'b1; wideRow = row; wideLaneEn = en; wideWdata = d;
    @(negedge clk);
    wideEn = 1'b0; wideWe = 1'b0; wideLaneEn = '0;
  endtask

  task automatic wideRead(input logic [4:0] row, output logic [255:0] d, output logic v);
    @(negedge clk);
    wideEn = 1'b1; wideWe = 1'b0; wideRow = row;
    @(negedge clk);
    wideEn = 1'b0;
    #1;
    d = wideRdata; v = wideRvalid;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vecs++; miss++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    logic [31:0]  rd;
    logic         err;
    int           waits;
    logic [255:0] row, pat, pat2;
    logic         v;

    rstN = 1'b0; wideEn = 0; wideWe = 0; wideRow = 0; wideLaneEn = 0; wideWdata = 0;
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0; pstrb = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 wideRvalid", 256'(wideRvalid), 256'd0);
    chk("R1 wideRdata", wideRdata, 256'd0);
    chk("R1 pready", 256'(pready), 256'd0);
    chk("R1 pslverr", 256'(pslverr), 256'd0);

    // Table walk: narrow port map, strobes, window errors (R4, R5, R6)
    for (int i = 0; i < NV; i++) begin
      apbXfer(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].strb, rd, err, waits);
      chk($sformatf("R%0d vec%0d err", VECS[i].req, i), 256'(err), 256'(VECS[i].err));
      chk($sformatf("R%0d vec%0d waits", VECS[i].req, i), 256'(waits), 256'd0);
      if (!VECS[i].wr)
        chk($sformatf("R%0d vec%0d rdata", VECS[i].req, i), 256'(rd), 256'(VECS[i].exp));
    end

    // R3 lane order on rows written through the narrow port
    wideRead(5'd31, row, v);
    chk("R3 valid", 256'(v), 256'd1);
    chk("R3 bank7 high bits", 256'(row[255:224]), 256'h0AABBCCDD);
    wideRead(5'd0, row, v);
    chk("R3 bank0 low bits", 256'(row[31:0]), 256'h11FF33FF);
    wideRead(5'd1, row, v);
    chk("R3 bank1", 256'(row[63:32]), 256'hCAFEF00D);
    @(negedge clk); #1;
    chk("R3 valid drops", 256'(wideRvalid), 256'd0);

    // R2 full and partial wide writes
    for (int i = 0; i < 8; i++) pat[i*32 +: 32] = 32'hA0A0_0000 | i;
    wideWrite(5'd2, 8'hFF, pat);
    wideRead(5'd2, row, v);
    chk("R2 full row", row, pat);
    apbXfer(1'b0, 32'h0000_C048, 32'h0, 4'h0, rd, err, waits);
    chk("R4 row2 bank2", 256'(rd), 256'hA0A00002);
    wideWrite(5'd2, 8'h04, {8{32'h5555_5555}});
    pat2 = pat; pat2[95:64] = 32'h5555_5555;
    wideRead(5'd2, row, v);
    chk("R2 one lane", row, pat2);
    apbXfer(1'b0, 32'h0000_C04C, 32'h0, 4'h0, rd, err, waits);
    chk("R2 neighbour lane kept", 256'(rd), 256'hA0A00003);

    // R7 same-row clash: wide write wins, one wait state
    for (int i = 0; i < 8; i++) pat[i*32 +: 32] = 32'hC0DE_0000 | i;
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = 32'h0000_C048;
    @(negedge clk);
    penable = 1; wideEn = 1; wideWe = 1; wideRow = 5'd2; wideLaneEn = 8'hFF; wideWdata = pat;
    #1;
    chk("R7 wait state", 256'(pready), 256'd0);
    @(negedge clk);
    wideEn = 0; wideWe = 0; wideLaneEn = 0;
    #1;
    chk("R7 completes", 256'(pready), 256'd1);
    chk("R7 sees wide data", 256'(prdata), 256'hC0DE0002);
    @(negedge clk);
    psel = 0; penable = 0;

    // R8 other-row wide write alongside a narrow read
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = 32'h0000_C048;
    @(negedge clk);
    penable = 1; wideEn = 1; wideWe = 1; wideRow = 5'd5; wideLaneEn = 8'hFF; wideWdata = '1;
    #1;
    chk("R8 no wait", 256'(pready), 256'd1);
    chk("R8 data", 256'(prdata), 256'hC0DE0002);
    @(negedge clk);
    psel = 0; penable = 0; wideEn = 0; wideWe = 0; wideLaneEn = 0;
    wideRead(5'd5, row, v);
    chk("R8 wide write landed", row, {256{1'b1}});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule